// File: doc/BRIEF.md
# Prioritized Interrupt Controller for a Single Processor

The block collects a vector of peripheral interrupt lines and tracks, for every line, whether it is pending and whether the processor has taken it. Each line carries a programmable priority, an enable bit and a trigger type, which is either edge or level. Every cycle an arbiter looks at all lines that are pending, enabled and not already taken, and picks the most urgent one. That choice is held in a register. The processor interrupt output is raised only when the interface enable is set and the winner's priority value lies strictly below a programmable threshold.

Software reaches the block through a small word-addressed register port. Writes take effect on the clock edge where `reg_wr` is sampled high. A read of the acknowledge address returns the winner's ID on `reg_rdata` one cycle later and marks that source as taken. A later write of the same ID to the end-of-interrupt address releases it. Line n is reported as ID 32+n. IDs below 32 are reserved for processor-local and software interrupts, which this block does not generate. ID 1023 means "nothing to take".

The register map is: 0 control (bit 0 is the interface enable), 1 priority threshold, 2 acknowledge (read), 3 end of interrupt (write), 4 enable vector, 5 trigger vector, and 64+n the priority of line n.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all lines are disabled, level-triggered and at priority 0, the interface enable and threshold are 0, `irq_out` is low, and an acknowledge read returns 1023.
- R2: Acknowledging line n returns ID 32+n on `reg_rdata`.
- R3: Among the candidate lines, the one with the numerically lowest priority value (address 64+n) is selected. On equal values the lower line number wins.
- R4: A line whose bit in the enable vector (address 4) is 0 never raises `irq_out` and is never returned by an acknowledge.
- R5: A line is signalled only if its priority value is strictly less than the threshold at address 1. A value equal to the threshold is held back.
- R6: `irq_out` stays low, and acknowledges return 1023, while control bit 0 (address 0) is clear.
- R7: A read of address 2 marks the returned line active. An active line is not offered again until it is released, even if it is still asserted.
- R8: A write to address 3 of the ID of an active line clears its active state. A write of any other ID has no effect.
- R9: An acknowledge that finds no qualifying line returns 1023 and changes no pending or active state.
- R10: A line with trigger bit 1 (address 5) latches pending on a rising edge and stays pending after the line falls. The acknowledge clears that latch. A new rising edge while the line is active pends it again.
- R11: A line with trigger bit 0 is pending only while its input is high. If it drops before it is acknowledged, it is no longer signalled.
- R12: A new input level first shows at `irq_out` after the second rising clock edge that samples it. The output is still low after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Peripheral interrupt lines, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Acknowledge result, valid the cycle after the read |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench targets the following corner cases:

- **Priority ties.** A design that broke ties toward the higher line number would return the wrong ID first.
- **Threshold equality.** An off-by-one comparison would forward a source whose priority equals the threshold.
- **Level source still asserted after acknowledge.** If the active state were not honoured, the source would be re-presented at once. If end of interrupt were not honoured, it would never come back.
- **Short edge pulses.** These show whether an edge latch holds, and whether it clears on acknowledge.
- **Wrong-ID end of interrupt.** This must leave the source active.
- **Back-to-back acknowledges.** These expose a stale registered winner being handed out twice.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_SRC       = 32,
  parameter int PRIO_W      = 8,
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int SPI_BASE    = 32,
  parameter int SPURIOUS_ID = 1023,
  parameter int PRIO_BASE   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq_out
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_PMASK = AW'(1);
  localparam logic [AW-1:0] A_ACK   = AW'(2);
  localparam logic [AW-1:0] A_EOI   = AW'(3);
  localparam logic [AW-1:0] A_EN    = AW'(4);
  localparam logic [AW-1:0] A_TRIG  = AW'(5);

  logic              ctrl_en;
  logic [PRIO_W-1:0] pmask;
  logic [N_SRC-1:0]  en_q, trig_q, irq_q, edge_pend, active_q;
  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic              best_valid_q;
  logic [IDX_W-1:0]  best_idx_q;
  logic [PRIO_W-1:0] best_prio_q;
  logic [DW-1:0]     rdata_q;

  wire [N_SRC-1:0] pend = (trig_q & edge_pend) | (~trig_q & irq_q);
  wire [N_SRC-1:0] cand = pend & en_q & ~active_q;

  logic              found;
  logic [IDX_W-1:0]  bidx;
  logic [PRIO_W-1:0] bprio;
  always_comb begin
    found = 1'b0;
    bidx  = '0;
    bprio = '1;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (!found || prio_q[i] <= bprio)) begin
        found = 1'b1;
        bidx  = IDX_W'(i);
        bprio = prio_q[i];
      end
    end
  end

  wire qualify = ctrl_en & best_valid_q & cand[best_idx_q] & (best_prio_q < pmask);
  wire ack     = reg_rd & (reg_addr == A_ACK);
  wire take    = ack & qualify;

  wire [DW-1:0]    eoi_off = reg_wdata - DW'(SPI_BASE);
  wire             eoi_in  = (reg_wdata >= DW'(SPI_BASE)) && (eoi_off < DW'(N_SRC));
  wire [IDX_W-1:0] eoi_idx = eoi_off[IDX_W-1:0];
  wire             eoi_hit = reg_wr && (reg_addr == A_EOI) && eoi_in && active_q[eoi_idx];

  wire [N_SRC-1:0] take_vec = take ? (N_SRC'(1) << best_idx_q) : '0;
  wire [N_SRC-1:0] eoi_vec  = eoi_hit ? (N_SRC'(1) << eoi_idx) : '0;

  wire [AW-1:0] prio_off = reg_addr - AW'(PRIO_BASE);
  wire          prio_wr  = reg_wr && (reg_addr >= AW'(PRIO_BASE)) && (prio_off < AW'(N_SRC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en      <= 1'b0;
      pmask        <= '0;
      en_q         <= '0;
      trig_q       <= '0;
      irq_q        <= '0;
      edge_pend    <= '0;
      active_q     <= '0;
      best_valid_q <= 1'b0;
      best_idx_q   <= '0;
      best_prio_q  <= '0;
      rdata_q      <= '0;
      for (int i = 0; i < N_SRC; i++) prio_q[i] <= '0;
    end else begin
      irq_q     <= irq_in;
      edge_pend <= (edge_pend & ~take_vec) | (irq_in & ~irq_q & trig_q);
      active_q  <= (active_q & ~eoi_vec) | take_vec;
      best_valid_q <= found & ~take;
      best_idx_q   <= bidx;
      best_prio_q  <= bprio;
      if (ack)
        rdata_q <= take ? DW'(SPI_BASE) + DW'(best_idx_q) : DW'(SPURIOUS_ID);
      if (reg_wr) begin
        if (reg_addr == A_CTRL)  ctrl_en <= reg_wdata[0];
        if (reg_addr == A_PMASK) pmask   <= reg_wdata[PRIO_W-1:0];
        if (reg_addr == A_EN)    en_q    <= reg_wdata[N_SRC-1:0];
        if (reg_addr == A_TRIG)  trig_q  <= reg_wdata[N_SRC-1:0];
        if (prio_wr) prio_q[prio_off[IDX_W-1:0]] <= reg_wdata[PRIO_W-1:0];
      end
    end
  end

  assign irq_out   = qualify;
  assign reg_rdata = rdata_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_SRC       = 32,
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int SPI_BASE    = 32,
  parameter int SPURIOUS_ID = 1023
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_rdata,
  input logic             irq_out,
  input logic [N_SRC-1:0] active
);
  wire ack_rd = reg_rd && (reg_addr == AW'(2));
  wire eoi_wr = reg_wr && (reg_addr == AW'(3));

  a_r9_spurious_id: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !irq_out) |=> reg_rdata == DW'(SPURIOUS_ID));

  a_r9_spurious_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !irq_out) |=> $stable(active));

  a_r2_ack_id_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && irq_out) |=> (reg_rdata >= DW'(SPI_BASE)) && (reg_rdata < DW'(SPI_BASE + N_SRC)));

  a_r7_no_double_take: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && irq_out) |=> !irq_out);

  a_r7_active_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((active & ~$past(active)) != '0) |-> ($past(ack_rd) && $countones(active & ~$past(active)) == 1));

  a_r8_release_only_on_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_wr |=> ((~active & $past(active)) == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .N_SRC(N_SRC), .AW(AW), .DW(DW), .SPI_BASE(SPI_BASE), .SPURIOUS_ID(SPURIOUS_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq_out(irq_out), .active(active_q)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  localparam int N = 32;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_out;
  logic [31:0]   en_sh = '0;
  int checks = 0, errors = 0;

  irq_prio_ctrl dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out));

  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = 32'(d);
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic enable(input int n, input bit on);
    en_sh[n] = on;
    wr(4, en_sh);
  endtask

  task automatic ack(input string req, input int exp);
    tick(2);
    reg_rd = 1'b1; reg_addr = 8'd2;
    tick(1);
    reg_rd = 1'b0;
    chk(req, reg_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R1 irq_out after reset", irq_out, 0);
    ack("R1 ack after reset", 1023);
  endtask

  task automatic t_latency_level;
    wr(0, 1); wr(1, 255);
    wr(64 + 5, 10); enable(5, 1); tick(2);
    irq_in[5] = 1'b1;
    tick(1); chk("R12 low after first edge", irq_out, 0);
    tick(1); chk("R12 high after second edge", irq_out, 1);
    ack("R2 line 5 id", 37);
    tick(2); chk("R7 active level not re-offered", irq_out, 0);
    wr(3, 37);
    tick(2); chk("R8 eoi re-offers held level", irq_out, 1);
    irq_in[5] = 1'b0;
    tick(2); chk("R11 level drop withdraws", irq_out, 0);
    ack("R11 dropped level not taken", 1023);
    enable(5, 0);
  endtask

  task automatic t_arbitration;
    wr(64 + 3, 20); wr(64 + 7, 8); wr(64 + 9, 8);
    enable(3, 1); enable(7, 1); enable(9, 1);
    irq_in[3] = 1'b1; irq_in[7] = 1'b1; irq_in[9] = 1'b1;
    tick(3);
    ack("R3 tie to lower line", 39);
    ack("R3 second of tie", 41);
    ack("R3 lowest urgency last", 35);
    ack("R7 all active nothing left", 1023);
    wr(3, 39); wr(3, 41); wr(3, 35);
    irq_in[3] = 1'b0; irq_in[7] = 1'b0; irq_in[9] = 1'b0;
    en_sh = '0; wr(4, 0); tick(2);
  endtask

  task automatic t_enable;
    wr(64 + 12, 1); wr(64 + 2, 50);
    enable(2, 1);
    irq_in[12] = 1'b1; irq_in[2] = 1'b1;
    tick(3);
    ack("R4 disabled line skipped", 34);
    wr(3, 34); irq_in[2] = 1'b0;
    tick(3); chk("R4 disabled line no irq", irq_out, 0);
    ack("R4 disabled line not taken", 1023);
    irq_in[12] = 1'b0; enable(2, 0);
  endtask

  task automatic t_mask;
    wr(1, 20); wr(64 + 4, 20); enable(4, 1);
    irq_in[4] = 1'b1;
    tick(3); chk("R5 equal to threshold held", irq_out, 0);
    ack("R5 equal to threshold not taken", 1023);
    wr(64 + 4, 19);
    tick(3); chk("R5 below threshold signalled", irq_out, 1);
    ack("R5 below threshold id", 36);
    wr(3, 36); irq_in[4] = 1'b0; enable(4, 0); wr(1, 255);
  endtask

  task automatic t_ctrl_eoi;
    wr(0, 0); wr(64 + 6, 3); enable(6, 1);
    irq_in[6] = 1'b1;
    tick(3); chk("R6 gated when disabled", irq_out, 0);
    ack("R9 spurious while gated", 1023);
    wr(0, 1);
    tick(3); chk("R9 state kept after spurious", irq_out, 1);
    ack("R6 id after enable", 38);
    wr(3, 39);
    tick(3); chk("R8 wrong id ignored", irq_out, 0);
    wr(3, 38);
    tick(3); chk("R8 matching id releases", irq_out, 1);
    ack("R8 retaken after release", 38);
    wr(3, 38); irq_in[6] = 1'b0; enable(6, 0); tick(2);
  endtask

  task automatic t_edge;
    wr(5, 32'h400); wr(64 + 10, 4); enable(10, 1);
    irq_in[10] = 1'b1; tick(1); irq_in[10] = 1'b0;
    tick(4); chk("R10 edge latched after pulse", irq_out, 1);
    ack("R10 edge id", 42);
    tick(3); chk("R10 latch cleared by ack", irq_out, 0);
    irq_in[10] = 1'b1; tick(1); irq_in[10] = 1'b0;
    tick(3); chk("R10 held while active", irq_out, 0);
    wr(3, 42);
    tick(3); chk("R10 re-pended edge offered", irq_out, 1);
    ack("R10 re-pended id", 42);
    wr(3, 42);
    tick(3); chk("R10 idle after second service", irq_out, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_latency_level();
    t_arbitration();
    t_enable();
    t_mask();
    t_ctrl_eoi();
    t_edge();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule